// File: doc/BRIEF.md
# Reset and clock control register

This block is one 64-bit control and status register on a simple single-cycle register bus. It holds the settings for the system PLL and the two clock dividers, and it starts a chip-wide soft reset. Software writes the divider ratios, the PLL feedback code, the bypass, test and mode bits into a pending copy, which can be read back at once. The divider and PLL outputs keep their old values until a write also sets the soft-reset bit.

That soft-reset write gets no write acknowledge, so bus traffic stops before reset is asserted. The block then raises `chip_rst` for a fixed window and loads the pending settings into the active outputs during that window. After the window it releases reset, optionally only once the synchronized PLL lock input is high, and it clears the soft-reset bit. The power-down and PLL-reset bits act on their outputs straight away. The software flag bits are cleared only by power-on reset, and the lock status bit is read-only.

Top module: `rcc_ctl`

## Requirements
- R1: After power-on reset every stored bit reads 0, `chip_rst` is 0, both active divider ratios are 2, and the feedback, bypass, test and mode outputs are 0.
- R2: A write with bit 0 clear stores the divider (44:41 bus, 40:38 core), feedback (37:32), bypass (3), test (5:4) and mode (8:6) fields, and they read back on the next read. The active outputs do not change.
- R3: A write with bit 0 set loads the active outputs from the written fields while `chip_rst` is high: bus ratio = bus code + 2 (2..17), core ratio = core code + 2 (2..9), and the feedback code is passed through raw.
- R4: A write with bit 0 clear, made while `chip_rst` is low, is acknowledged on `bus_wack` exactly one cycle later. A write with bit 0 set gets no acknowledge.
- R5: With lock waiting off (bit 24 = 0), `chip_rst` rises in the cycle after the soft-reset write and stays high for exactly RST_CYCLES (16) cycles.
- R6: With bit 24 = 1, `chip_rst` stays high after the window until the synchronized `pll_lock` is 1, and it then falls within a few cycles.
- R7: Flag bits 31:26 keep their value through soft reset and clear to 0 on power-on reset.
- R8: Bit 25 reads the synchronized `pll_lock` level. Writes to bit 25 have no effect.
- R9: Bit 1 (power-down) and bit 2 (PLL reset) drive `pll_pd` and `pll_rst` from the cycle after the write, with no soft reset needed.
- R10: Bits 63:45 and 23:9 store the written value and read it back.
- R11: Bit 0 reads 1 while the reset sequence runs and 0 after it ends. Writes made while `chip_rst` is high are dropped and get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| bus_wack | output | 1 | Write acknowledge, one cycle after an accepted write |
| pll_lock | input | 1 | PLL lock, asynchronous |
| chip_rst | output | 1 | Chip-wide soft reset |
| pll_pd | output | 1 | PLL power-down, immediate |
| pll_rst | output | 1 | PLL reset, immediate |
| act_bus_ratio | output | 5 | Active bus-clock divide ratio |
| act_core_ratio | output | 4 | Active core-clock divide ratio |
| act_fbdiv | output | 6 | Active PLL feedback code |
| act_bypass | output | 1 | Active PLL bypass |
| act_test | output | 2 | Active test field |
| act_mode | output | 3 | Active mode field |

## Verification
The assertions assume that `por` is a synchronous pulse. They also assume that the bus strobes are single-cycle and sampled on the rising edge, so a write's effect on the acknowledge and the immediate bits can be judged one cycle later. The lock input is treated as asynchronous: no property depends on its exact arrival cycle, only on the minimum width of the reset window and on the active outputs staying frozen outside it. The stimulus changes every input on the falling clock edge, holds each strobe for one cycle, and waits several cycles after each lock change before it reads or checks a release.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int REG_W      = 64;
  localparam int SRST_BIT   = 0;
  localparam int PD_BIT     = 1;
  localparam int PRST_BIT   = 2;
  localparam int BYP_BIT    = 3;
  localparam int TST_LO     = 4;
  localparam int TST_W      = 2;
  localparam int MODE_LO    = 6;
  localparam int MODE_W     = 3;
  localparam int LWAIT_BIT  = 24;
  localparam int LOCK_BIT   = 25;
  localparam int FLAG_LO    = 26;
  localparam int FLAG_W     = 6;
  localparam int FB_LO      = 32;
  localparam int FB_W       = 6;
  localparam int CORE_LO    = 38;
  localparam int CORE_W     = 3;
  localparam int BUSD_LO    = 41;
  localparam int BUSD_W     = 4;
  localparam int BUS_RAT_W  = BUSD_W + 1;
  localparam int CORE_RAT_W = CORE_W + 1;

  typedef struct packed {
    logic [BUSD_W-1:0] bus_code;
    logic [CORE_W-1:0] core_code;
    logic [FB_W-1:0]   fb;
    logic              bypass;
    logic [TST_W-1:0]  test;
    logic [MODE_W-1:0] mode;
  } stage_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_HOLD, SQ_LOCK} seq_state_e;

  function automatic stage_t pick_stage(input logic [REG_W-1:0] r);
    stage_t s;
    s.bus_code  = r[BUSD_LO +: BUSD_W];
    s.core_code = r[CORE_LO +: CORE_W];
    s.fb        = r[FB_LO +: FB_W];
    s.bypass    = r[BYP_BIT];
    s.test      = r[TST_LO +: TST_W];
    s.mode      = r[MODE_LO +: MODE_W];
    return s;
  endfunction
endpackage

// File: rtl/rcc_lock_sync.sv
module rcc_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (por) q <= 1'b0;
        else     q <= async_in;
      end
      assign sync_out = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (por) sh <= '0;
        else     sh <= {sh[STAGES-2:0], async_in};
      end
      assign sync_out = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rcc_regfile.sv
module rcc_regfile
  import rcc_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             seq_release,
  output logic [REG_W-1:0] reg_q
);
  localparam logic [REG_W-1:0] LOCK_MASK = REG_W'(1) << LOCK_BIT;

  always_ff @(posedge clk) begin
    if (por) begin
      reg_q <= '0;
    end else if (wr_en) begin
      reg_q <= wdata & ~LOCK_MASK;
    end else if (seq_release) begin
      reg_q[SRST_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/rcc_reset_seq.sv
module rcc_reset_seq
  import rcc_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic por,
  input  logic start,
  input  logic lock_wait,
  input  logic lock_s,
  output logic chip_rst,
  output logic load,
  output logic release_now
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  seq_state_e       state;
  logic [CW-1:0]    cnt;

  always_comb begin
    release_now = 1'b0;
    if (state == SQ_HOLD && cnt == LAST && !(lock_wait && !lock_s))
      release_now = 1'b1;
    else if (state == SQ_LOCK && lock_s)
      release_now = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      chip_rst <= 1'b0;
      load     <= 1'b0;
    end else begin
      load <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            state    <= SQ_HOLD;
            cnt      <= '0;
            chip_rst <= 1'b1;
            load     <= 1'b1;
          end
        end
        SQ_HOLD: begin
          if (cnt == LAST) begin
            if (release_now) begin
              state    <= SQ_IDLE;
              chip_rst <= 1'b0;
            end else begin
              state <= SQ_LOCK;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_LOCK: begin
          if (release_now) begin
            state    <= SQ_IDLE;
            chip_rst <= 1'b0;
          end
        end
        default: begin
          state    <= SQ_IDLE;
          chip_rst <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rcc_active_set.sv
module rcc_active_set
  import rcc_pkg::*;
(
  input  logic                  clk,
  input  logic                  por,
  input  logic                  load,
  input  stage_t                pending,
  output logic [BUS_RAT_W-1:0]  bus_ratio,
  output logic [CORE_RAT_W-1:0] core_ratio,
  output logic [FB_W-1:0]       fb,
  output logic                  bypass,
  output logic [TST_W-1:0]      test,
  output logic [MODE_W-1:0]     mode
);
  always_ff @(posedge clk) begin
    if (por) begin
      bus_ratio  <= BUS_RAT_W'(2);
      core_ratio <= CORE_RAT_W'(2);
      fb         <= '0;
      bypass     <= 1'b0;
      test       <= '0;
      mode       <= '0;
    end else if (load) begin
      bus_ratio  <= {1'b0, pending.bus_code} + BUS_RAT_W'(2);
      core_ratio <= {1'b0, pending.core_code} + CORE_RAT_W'(2);
      fb         <= pending.fb;
      bypass     <= pending.bypass;
      test       <= pending.test;
      mode       <= pending.mode;
    end
  end
endmodule

// File: rtl/rcc_ctl.sv
module rcc_ctl
  import rcc_pkg::*;
#(
  parameter int RST_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  por,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  output logic                  bus_rvalid,
  output logic                  bus_wack,
  input  logic                  pll_lock,
  output logic                  chip_rst,
  output logic                  pll_pd,
  output logic                  pll_rst,
  output logic [BUS_RAT_W-1:0]  act_bus_ratio,
  output logic [CORE_RAT_W-1:0] act_core_ratio,
  output logic [FB_W-1:0]       act_fbdiv,
  output logic                  act_bypass,
  output logic [TST_W-1:0]      act_test,
  output logic [MODE_W-1:0]     act_mode
);
  logic             lock_s;
  logic             wr_ok;
  logic             start;
  logic             load;
  logic             release_now;
  logic [REG_W-1:0] reg_q;
  stage_t           pending;

  assign wr_ok   = bus_wr && !chip_rst;
  assign start   = wr_ok && bus_wdata[SRST_BIT];
  assign pending = pick_stage(reg_q);
  assign pll_pd  = reg_q[PD_BIT];
  assign pll_rst = reg_q[PRST_BIT];

  rcc_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por(por), .async_in(pll_lock), .sync_out(lock_s)
  );

  rcc_regfile u_reg (
    .clk(clk), .por(por), .wr_en(wr_ok), .wdata(bus_wdata),
    .seq_release(release_now), .reg_q(reg_q)
  );

  rcc_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .por(por), .start(start), .lock_wait(reg_q[LWAIT_BIT]),
    .lock_s(lock_s), .chip_rst(chip_rst), .load(load),
    .release_now(release_now)
  );

  rcc_active_set u_act (
    .clk(clk), .por(por), .load(load), .pending(pending),
    .bus_ratio(act_bus_ratio), .core_ratio(act_core_ratio),
    .fb(act_fbdiv), .bypass(act_bypass), .test(act_test), .mode(act_mode)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_wack   <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_wack   <= wr_ok && !bus_wdata[SRST_BIT];
      if (bus_rd) begin
        bus_rdata           <= reg_q;
        bus_rdata[LOCK_BIT] <= lock_s;
      end
    end
  end
endmodule

// File: rtl/rcc_ctl_chk.sv
module rcc_ctl_chk
  import rcc_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input logic                  clk,
  input logic                  por,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [REG_W-1:0]      bus_wdata,
  input logic                  bus_rvalid,
  input logic                  bus_wack,
  input logic                  chip_rst,
  input logic                  pll_pd,
  input logic [BUS_RAT_W-1:0]  act_bus_ratio,
  input logic [CORE_RAT_W-1:0] act_core_ratio,
  input logic [FB_W-1:0]       act_fbdiv,
  input logic                  act_bypass,
  input logic [TST_W-1:0]      act_test,
  input logic [MODE_W-1:0]     act_mode
);
  localparam int HW = $clog2(RST_CYCLES + 2) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (por) hi_cnt <= '0;
    else if (!chip_rst) hi_cnt <= '0;
    else if (hi_cnt != {HW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r4_no_ack_on_srst: assert property (@(posedge clk) disable iff (por)
    (bus_wr && !chip_rst && bus_wdata[0]) |=> !bus_wack);

  a_r4_ack_plain: assert property (@(posedge clk) disable iff (por)
    (bus_wr && !chip_rst && !bus_wdata[0]) |=> bus_wack);

  a_r11_drop_busy: assert property (@(posedge clk) disable iff (por)
    chip_rst |=> !bus_wack);

  a_r5_min_window: assert property (@(posedge clk) disable iff (por)
    $fell(chip_rst) |-> (hi_cnt >= HW'(RST_CYCLES)));

  a_r3_frozen_outside: assert property (@(posedge clk) disable iff (por)
    !chip_rst |=> ($stable(act_bus_ratio) && $stable(act_core_ratio) &&
                   $stable(act_fbdiv) && $stable(act_bypass) &&
                   $stable(act_test) && $stable(act_mode)));

  a_r3_ratio_range: assert property (@(posedge clk) disable iff (por)
    (act_bus_ratio >= BUS_RAT_W'(2)) && (act_bus_ratio <= BUS_RAT_W'(17)) &&
    (act_core_ratio >= CORE_RAT_W'(2)) && (act_core_ratio <= CORE_RAT_W'(9)));

  a_r9_pd_immediate: assert property (@(posedge clk) disable iff (por)
    (bus_wr && !chip_rst) |=> (pll_pd == $past(bus_wdata[1])));

  a_r2_read_valid: assert property (@(posedge clk) disable iff (por)
    bus_rd |=> bus_rvalid);
endmodule

bind rcc_ctl rcc_ctl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .por(por), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_wack(bus_wack),
  .chip_rst(chip_rst), .pll_pd(pll_pd), .act_bus_ratio(act_bus_ratio),
  .act_core_ratio(act_core_ratio), .act_fbdiv(act_fbdiv),
  .act_bypass(act_bypass), .act_test(act_test), .act_mode(act_mode)
);

// File: tb/rcc_ctl_test.sv
module rcc_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC = 16;

  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid, bus_wack;
  logic        pll_lock = 1'b1;
  logic        chip_rst, pll_pd, pll_rst;
  logic [4:0]  act_bus_ratio;
  logic [3:0]  act_core_ratio;
  logic [5:0]  act_fbdiv;
  logic        act_bypass;
  logic [1:0]  act_test;
  logic [2:0]  act_mode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rcc_ctl #(.RST_CYCLES(RST_CYC), .SYNC_STAGES(2)) uut (
    .clk(clk), .por(por), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_wack(bus_wack), .pll_lock(pll_lock), .chip_rst(chip_rst),
    .pll_pd(pll_pd), .pll_rst(pll_rst), .act_bus_ratio(act_bus_ratio),
    .act_core_ratio(act_core_ratio), .act_fbdiv(act_fbdiv),
    .act_bypass(act_bypass), .act_test(act_test), .act_mode(act_mode)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected read data", bus_rdata, 64'hx);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [63:0] d, input logic exp_ack, input string tag);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(tag, {63'd0, bus_wack}, {63'd0, exp_ack});
  endtask

  task automatic bus_read(input logic [63:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 400 && chip_rst; i++) @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk);
    por = 1'b1;
    idle(3);
    por = 1'b0;
    idle(3);
  endtask

  function automatic logic [63:0] fields(input logic [3:0] b, input logic [2:0] c,
      input logic [5:0] f, input logic byp, input logic [1:0] t, input logic [2:0] m);
    logic [63:0] v = '0;
    v[44:41] = b; v[40:38] = c; v[37:32] = f;
    v[3] = byp; v[5:4] = t; v[8:6] = m;
    return v;
  endfunction

  localparam logic [63:0] LOCK1 = 64'h1 << 25;

  initial begin
    logic [63:0] d;
    idle(4);
    por = 1'b0;
    idle(3);

    // R1 defaults
    chk("R1 chip_rst", {63'd0, chip_rst}, 64'd0);
    chk("R1 bus ratio", {59'd0, act_bus_ratio}, 64'd2);
    chk("R1 core ratio", {60'd0, act_core_ratio}, 64'd2);
    chk("R1 fb/byp/test/mode", {52'd0, act_fbdiv, act_bypass, act_test, act_mode}, 64'd0);
    bus_read(LOCK1, "R1 reset read");

    // R2 staged write, R4 ack
    d = fields(4'hA, 3'h5, 6'h2B, 1'b1, 2'd2, 3'd5);
    bus_write(d, 1'b1, "R4 plain write ack");
    bus_read(d | LOCK1, "R2 pending read back");
    idle(2);
    chk("R2 active bus unchanged", {59'd0, act_bus_ratio}, 64'd2);
    chk("R2 active fb unchanged", {58'd0, act_fbdiv}, 64'd0);

    // R3/R5 soft reset write
    bus_write(d | 64'h1, 1'b0, "R4 srst write no ack");
    chk("R5 chip_rst first cycle", {63'd0, chip_rst}, 64'd1);
    for (int i = 0; i < RST_CYC - 1; i++) begin
      @(negedge clk);
      chk("R5 chip_rst held", {63'd0, chip_rst}, 64'd1);
    end
    @(negedge clk);
    chk("R5 chip_rst released", {63'd0, chip_rst}, 64'd0);
    chk("R3 bus ratio", {59'd0, act_bus_ratio}, 64'd12);
    chk("R3 core ratio", {60'd0, act_core_ratio}, 64'd7);
    chk("R3 fb raw", {58'd0, act_fbdiv}, 64'h2B);
    chk("R3 byp/test/mode", {58'd0, act_bypass, act_test, act_mode}, {58'd0, 1'b1, 2'd2, 3'd5});
    bus_read(d | LOCK1, "R11 bit0 cleared after sequence");

    // R3 boundary codes, R7 flags, R10 reserved
    d = fields(4'hF, 3'h7, 6'h3F, 1'b0, 2'd0, 3'd0);
    d[31:26] = 6'h2D;
    d[63:45] = 19'h5A5A5;
    d[23:9]  = 15'h1234;
    bus_write(d | 64'h1, 1'b0, "R4 srst write no ack");
    wait_release();
    idle(1);
    chk("R3 max bus ratio", {59'd0, act_bus_ratio}, 64'd17);
    chk("R3 max core ratio", {60'd0, act_core_ratio}, 64'd9);
    bus_read(d | LOCK1, "R7 R10 flags and reserved kept");
    do_por();
    bus_read(LOCK1, "R7 flags cleared by por");
    chk("R1 ratio after por", {59'd0, act_bus_ratio}, 64'd2);

    // R9 immediate bits
    bus_write(64'h2, 1'b1, "R9 pd write ack");
    chk("R9 pll_pd immediate", {63'd0, pll_pd}, 64'd1);
    bus_write(64'h4, 1'b1, "R9 rst write ack");
    chk("R9 pll_rst immediate", {62'd0, pll_rst, pll_pd}, 64'd2);
    chk("R9 no reset started", {63'd0, chip_rst}, 64'd0);

    // R8 lock bit
    pll_lock = 1'b0;
    idle(4);
    bus_write(LOCK1, 1'b1, "R8 write lock bit ack");
    bus_read(64'd0, "R8 lock bit read-only");
    pll_lock = 1'b1;
    idle(4);
    bus_read(LOCK1, "R8 lock reflected");

    // R6 lock wait, R11 drop while busy
    pll_lock = 1'b0;
    idle(4);
    d = (64'h1 << 24) | fields(4'h3, 3'h1, 6'h11, 1'b0, 2'd1, 3'd2);
    bus_write(d | 64'h1, 1'b0, "R4 srst write no ack");
    idle(RST_CYC + 20);
    chk("R6 held waiting for lock", {63'd0, chip_rst}, 64'd1);
    bus_write(64'hFFFF_0000_0000_0000, 1'b0, "R11 busy write no ack");
    bus_read(d | 64'h1, "R11 bit0 set and busy write dropped");
    pll_lock = 1'b1;
    idle(6);
    chk("R6 released after lock", {63'd0, chip_rst}, 64'd0);
    chk("R3 bus ratio after wait", {59'd0, act_bus_ratio}, 64'd5);
    bus_read(d | LOCK1, "R11 bit0 cleared after lock wait");

    idle(4);
    chk("R2 all reads returned", exp_q.size(), 64'd0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule